// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Break and Compare

This block takes a serial line and rebuilds characters from it. It counts sampling ticks at either one or sixteen ticks per bit. A falling edge seen while idle is checked again at the middle of the start bit, and a glitch is thrown away at that point. Each finished character goes into a single holding register with its own error and match flags. The register is emptied by a one-cycle read strobe.

When a character arrives with no stop bit, the receiver searches for the next start edge half a bit time later. It does not wait for a full bit boundary. A character that is all zeros (including a zero parity bit) with a missing stop bit is treated as a line break. The receiver pulses a break-start event and then ignores the line until it returns high, at which point it pulses a break-end event. Each stored character is also compared against a programmed value, and the result can be gated onto an interrupt output.

Top module: `async_rx_brk`

## Requirements
- R1: In 16X mode a low seen while idle is accepted as a start bit only if the line is still low 8 ticks later. Otherwise the receiver returns to idle and produces no character.
- R2: `cfg_x16`=1 samples each data, parity and stop bit 16 ticks after the previous sample, starting from the start-bit midpoint. `cfg_x16`=0 accepts the start on the first low tick and samples one bit on each following tick.
- R3: `cfg_len` 0..3 selects 5..8 data bits, received LSB first. Unused upper bits of `rx_data` read 0, and `rx_valid` rises in the cycle after the stop-bit sample.
- R4: `cfg_par` selects the parity mode: 00 none, 01 even, 10 odd, 11 forced to the level `cfg_pfrc`. `par_err` is set for a stored character whose parity bit breaks the selected rule.
- R5: A stored character whose stop bit sampled low has `frm_err` set.
- R6: After a framing error in 16X mode, the start-bit search resumes 8 ticks after the stop sample. A start bit that follows directly after a low stop bit is therefore received correctly.
- R7: Zero data, a zero or absent parity bit and a low stop bit together form a break. `brk_start` pulses for one cycle, nothing is stored, and no character is received while the line stays low.
- R8: After a break, the first tick that sees the line high gives a one-cycle `brk_end` pulse, and reception resumes.
- R9: A character that completes while `rx_valid` is set and `rd` is low sets `ovr_err` and keeps the stored character. `rd` clears `rx_valid`, `ovr_err` and all character flags.
- R10: `rx_match` is set when the stored character equals `cmp_char` masked to the character length. `match_irq` is `rx_match` gated by `cmp_irq_en`.
- R11: While `samp_en` is low the receiver ignores the line: no character, no break event.
- R12: After reset, `rx_valid`, all flags and both break pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_en | input | 1 | Sampling tick enable |
| rxd | input | 1 | Serial line, idle high |
| cfg_x16 | input | 1 | 1: 16 ticks per bit, 0: 1 tick per bit |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par | input | 2 | Parity mode |
| cfg_pfrc | input | 1 | Level expected in forced-parity mode |
| cmp_char | input | 8 | Compare value |
| cmp_irq_en | input | 1 | Enables the match interrupt |
| rd | input | 1 | Read strobe for the holding register |
| rx_valid | output | 1 | Holding register full |
| rx_data | output | 8 | Stored character |
| par_err | output | 1 | Parity error of stored character |
| frm_err | output | 1 | Framing error of stored character |
| ovr_err | output | 1 | A character was lost |
| rx_match | output | 1 | Stored character equals compare value |
| match_irq | output | 1 | Match interrupt |
| brk_start | output | 1 | One-cycle break-detected pulse |
| brk_end | output | 1 | One-cycle break-ended pulse |

## Verification
The hardest case to reach is the half-bit resynchronisation. It only shows when a frame with a low stop bit is followed at once by a start bit, so the line never rises between the two frames. To get there, the stimulus sends a nonzero frame with a low stop and then starts the next frame in the very next bit cell. It strobes a read during that start bit so the second character is actually stored and not lost to overrun. A receiver that searched for a start too early would lock onto the low stop bit, and one that searched too late would miss the real start edge. In both cases the stored data and framing flag come out wrong.

// File: rtl/async_rx_brk.sv
module async_rx_brk #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_en,
  input  logic       rxd,
  input  logic       cfg_x16,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic       cfg_pfrc,
  input  logic [7:0] cmp_char,
  input  logic       cmp_irq_en,
  input  logic       rd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err,
  output logic       rx_match,
  output logic       match_irq,
  output logic       brk_start,
  output logic       brk_end
);
  localparam int CW = $clog2(OVS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK, S_HUNT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          pbit;

  wire [CW-1:0] full    = cfg_x16 ? CW'(OVS-1) : '0;
  wire [CW-1:0] half    = cfg_x16 ? CW'(OVS/2-1) : '0;
  wire          at_full = (cnt == full);
  wire [2:0]    last    = 3'd4 + {1'b0, cfg_len};
  wire [1:0]    rsh     = 2'd3 - cfg_len;
  wire [7:0]    chr     = sh >> rsh;
  wire [7:0]    cmpm    = cmp_char & (8'hFF >> rsh);
  wire          par_on  = (cfg_par != 2'b00);
  wire          xr      = ^chr ^ pbit;

  logic par_bad;
  always_comb begin
    case (cfg_par)
      2'b01:   par_bad = xr;
      2'b10:   par_bad = ~xr;
      2'b11:   par_bad = (pbit != cfg_pfrc);
      default: par_bad = 1'b0;
    endcase
  end

  wire done   = samp_en && (st == S_STOP) && at_full;
  wire is_brk = (chr == 8'h00) && (!par_on || !pbit) && !rxd;
  wire load   = done && !is_brk;

  assign match_irq = rx_match & cmp_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bidx <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else if (samp_en) begin
      case (st)
        S_IDLE: if (!rxd) begin
          st   <= cfg_x16 ? S_START : S_DATA;
          cnt  <= '0;
          bidx <= '0;
          pbit <= 1'b0;
        end
        S_START: begin
          if (cnt == half) begin
            st  <= rxd ? S_IDLE : S_DATA;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (at_full) begin
            sh  <= {rxd, sh[7:1]};
            cnt <= '0;
            if (bidx == last) st <= par_on ? S_PAR : S_STOP;
            else bidx <= bidx + 3'd1;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (at_full) begin
            pbit <= rxd;
            st   <= S_STOP;
            cnt  <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (at_full) begin
            cnt <= '0;
            if (rxd)          st <= S_IDLE;
            else if (is_brk)  st <= S_BRK;
            else if (cfg_x16) st <= S_HUNT;
            else              st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_BRK: if (rxd) st <= S_IDLE;
        S_HUNT: begin
          if (cnt == half) begin
            cnt  <= '0;
            bidx <= '0;
            pbit <= 1'b0;
            st   <= rxd ? S_IDLE : S_START;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      par_err   <= 1'b0;
      frm_err   <= 1'b0;
      ovr_err   <= 1'b0;
      rx_match  <= 1'b0;
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
    end else begin
      brk_start <= done && is_brk;
      brk_end   <= samp_en && (st == S_BRK) && rxd;
      if (rd) begin
        rx_valid <= 1'b0;
        ovr_err  <= 1'b0;
        par_err  <= 1'b0;
        frm_err  <= 1'b0;
        rx_match <= 1'b0;
      end
      if (load) begin
        if (rx_valid && !rd) ovr_err <= 1'b1;
        else begin
          rx_valid <= 1'b1;
          rx_data  <= chr;
          par_err  <= par_on && par_bad;
          frm_err  <= !rxd;
          rx_match <= (chr == cmpm);
        end
      end
    end
  end
endmodule

module async_rx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       samp_en,
  input logic       rd,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       par_err,
  input logic       frm_err,
  input logic       ovr_err,
  input logic       rx_match,
  input logic       brk_start,
  input logic       brk_end
);
  AST_BRK_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) brk_start |=> !brk_start); // R7
  AST_BRK_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) brk_start |-> !$rose(rx_valid)); // R7
  AST_BRK_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n) brk_end |=> !brk_end); // R8
  AST_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rd) |=> $stable(rx_data)); // R9
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_err) |-> $past(rx_valid && !rd)); // R9
  AST_FLAGS_WITH_CHAR: assert property (@(posedge clk) disable iff (!rst_n) (par_err || frm_err || rx_match) |-> rx_valid); // R5
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!samp_en && !rd) |=> $stable(rx_valid)); // R11
  AST_GATED_NO_BRK: assert property (@(posedge clk) disable iff (!rst_n) !samp_en |=> (!brk_start && !brk_end)); // R11
endmodule

bind async_rx_brk async_rx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rd(rd), .rx_valid(rx_valid),
  .rx_data(rx_data), .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err),
  .rx_match(rx_match), .brk_start(brk_start), .brk_end(brk_end)
);

// File: tb/async_rx_brk_bench.sv
module async_rx_brk_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_en = 1'b1, rxd = 1'b1, cfg_x16 = 1'b1, cfg_pfrc = 1'b0;
  logic cmp_irq_en = 1'b0, rd = 1'b0;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0;
  logic [7:0] cmp_char = 8'h00;
  logic rx_valid, par_err, frm_err, ovr_err, rx_match, match_irq, brk_start, brk_end;
  logic [7:0] rx_data;

  int checks = 0, errors = 0, cycles = 0;
  bit mon_on = 0;
  bit e_valid = 0, e_perr = 0, e_ferr = 0, e_ovr = 0, e_match = 0, e_bs = 0, e_be = 0;
  logic [7:0] e_data = 0;

  always #2 clk = ~clk;

  async_rx_brk u_async_rx_brk (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd), .cfg_x16(cfg_x16),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_pfrc(cfg_pfrc), .cmp_char(cmp_char),
    .cmp_irq_en(cmp_irq_en), .rd(rd), .rx_valid(rx_valid), .rx_data(rx_data),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err), .rx_match(rx_match),
    .match_irq(match_irq), .brk_start(brk_start), .brk_end(brk_end)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    check(rx_valid == e_valid, "R3 valid", rx_valid, e_valid);
    check(ovr_err == e_ovr, "R9 overrun", ovr_err, e_ovr);
    check(brk_start == e_bs, "R7 break start", brk_start, e_bs);
    check(brk_end == e_be, "R8 break end", brk_end, e_be);
    if (e_valid) begin
      check(rx_data == e_data, "R3 data", rx_data, e_data);
      check(par_err == e_perr, "R4 parity", par_err, e_perr);
      check(frm_err == e_ferr, "R5 framing", frm_err, e_ferr);
      check(rx_match == e_match, "R10 match", rx_match, e_match);
      check(match_irq == (e_match & cmp_irq_en), "R10 irq", match_irq, e_match & cmp_irq_en);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic hold(int n); for (int i = 0; i < n; i++) tick(); endtask

  function automatic bit model_perr(logic [7:0] d, bit pb);
    case (cfg_par)
      2'd1: return (^d ^ pb) != 1'b0;
      2'd2: return (^d ^ pb) == 1'b0;
      2'd3: return pb != cfg_pfrc;
      default: return 1'b0;
    endcase
  endfunction

  task automatic clear_exp();
    e_valid = 0; e_ovr = 0; e_perr = 0; e_ferr = 0; e_match = 0;
  endtask

  task automatic do_read();
    rd = 1; tick(); rd = 0; clear_exp();
  endtask

  task automatic send(logic [7:0] d, bit pb, bit stop, bit rd_first);
    int p = cfg_x16 ? 16 : 1;
    int k = cfg_x16 ? 9 : 1;
    int n = int'(cfg_len) + 5;
    logic [7:0] dm = d & (8'hFF >> (3 - cfg_len));
    bit brk;
    rxd = 0;
    if (rd_first) begin rd = 1; tick(); rd = 0; clear_exp(); hold(p - 1); end
    else hold(p);
    for (int i = 0; i < n; i++) begin rxd = d[i]; hold(p); end
    if (cfg_par != 0) begin rxd = pb; hold(p); end
    rxd = stop;
    hold(k);
    brk = (dm == 0) && (cfg_par == 0 || !pb) && !stop;
    if (brk) begin
      e_bs = 1; tick(); e_bs = 0;
    end else begin
      if (e_valid) e_ovr = 1;
      else begin
        e_valid = 1; e_data = dm; e_perr = model_perr(dm, pb); e_ferr = !stop;
        e_match = (dm == (cmp_char & (8'hFF >> (3 - cfg_len))));
      end
      hold(p - k);
    end
  endtask

  task automatic end_break();
    rxd = 1; tick(); e_be = 1; tick(); e_be = 0;
  endtask

  initial begin
    hold(3);
    rst_n = 1;
    tick();
    check(!rx_valid && !ovr_err && !par_err && !frm_err && !brk_start && !brk_end,
          "R12 reset", {rx_valid, ovr_err, brk_start, brk_end}, 0);
    mon_on = 1;
    hold(4);
    // R2 R3: 16X, 8 bits, no parity
    send(8'hA5, 0, 1, 0); check(rx_data == 8'hA5, "R2 16x sample", rx_data, 8'hA5); do_read(); hold(3);
    // R3 R4: 5 bits even parity, good then bad
    cfg_len = 2'd0; cfg_par = 2'd1;
    send(8'h13, 1, 1, 0); do_read(); hold(2);
    send(8'h13, 0, 1, 0); check(par_err == 1, "R4 even bad", par_err, 1); do_read(); hold(2);
    // R4 odd and forced
    cfg_len = 2'd2; cfg_par = 2'd2;
    send(8'h55, 1, 1, 0); do_read(); hold(2);
    send(8'h55, 0, 1, 0); do_read(); hold(2);
    cfg_par = 2'd3; cfg_pfrc = 1;
    send(8'h2A, 0, 1, 0); check(par_err == 1, "R4 forced bad", par_err, 1); do_read(); hold(2);
    send(8'h2A, 1, 1, 0); do_read(); hold(2);
    // R10 compare
    cfg_par = 2'd0; cfg_len = 2'd3; cmp_char = 8'h3C; cmp_irq_en = 1;
    send(8'h3C, 0, 1, 0); check(match_irq == 1, "R10 irq on", match_irq, 1); do_read(); hold(2);
    cmp_irq_en = 0;
    send(8'h3C, 0, 1, 0); check(match_irq == 0, "R10 irq off", match_irq, 0); do_read(); hold(2);
    cfg_len = 2'd1; cmp_char = 8'hFC;
    send(8'h3C, 0, 1, 0); check(rx_match == 1, "R10 masked", rx_match, 1); do_read(); hold(2);
    send(8'h3D, 0, 1, 0); do_read(); hold(2);
    // R9 overrun
    cfg_len = 2'd3;
    send(8'h11, 0, 1, 0); send(8'h22, 0, 1, 0);
    check(ovr_err == 1 && rx_data == 8'h11, "R9 keep old", rx_data, 8'h11);
    do_read(); hold(2);
    // R1 false start
    rxd = 0; hold(4); rxd = 1; hold(40);
    check(rx_valid == 0, "R1 false start", rx_valid, 0);
    send(8'h5A, 0, 1, 0); do_read(); hold(2);
    // R5 R6 framing then back-to-back start
    send(8'h81, 0, 0, 0);
    check(frm_err == 1, "R5 framing", frm_err, 1);
    send(8'h42, 0, 1, 1);
    check(rx_data == 8'h42 && frm_err == 0, "R6 resync", rx_data, 8'h42);
    do_read(); hold(4);
    // R7 R8 break
    send(8'h00, 0, 0, 0); hold(40);
    check(rx_valid == 0, "R7 no char in break", rx_valid, 0);
    end_break(); hold(4);
    send(8'h33, 0, 1, 0); do_read(); hold(2);
    // R7 with even parity: zero parity bit makes a break
    cfg_par = 2'd1;
    send(8'h00, 0, 0, 0); hold(20); end_break(); hold(4);
    cfg_par = 2'd0;
    // R2 1X mode
    cfg_x16 = 0;
    send(8'h6B, 0, 1, 0); check(rx_data == 8'h6B, "R2 1x sample", rx_data, 8'h6B); do_read(); hold(2);
    send(8'h96, 0, 0, 0); send(8'h0F, 0, 1, 1); do_read(); hold(2);
    send(8'h00, 0, 0, 0); hold(10); end_break(); hold(3);
    send(8'hC3, 0, 1, 0); do_read(); hold(2);
    // R11 gated
    cfg_x16 = 1; samp_en = 0;
    rxd = 0; hold(300); rxd = 1; hold(5);
    check(rx_valid == 0 && brk_start == 0, "R11 gated", rx_valid, 0);
    samp_en = 1; hold(20);
    send(8'h7E, 0, 1, 0); do_read(); hold(4);
    mon_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule